// File: doc/BRIEF.md
# Converter Channel-Group Sequencer

This block decides when a successive-approximation converter starts a conversion, which channel-group slot owns it, and how many clock cycles the sample and conversion phases take. A small register-style write port loads one of several slots. Each slot holds a 5-bit channel number and an interrupt enable. A read strobe acknowledges a group's result. The analog part is a behavioural stub: the value on `ana_value` at the completing clock edge is taken as the raw 12-bit sample.

In software-trigger mode, writing slot 0 starts a conversion, and the other slots are only storage. In hardware-trigger mode, one request line per group starts that group's conversion. Several slots can then take turns ping-pong fashion, but only one group owns the converter at any moment. Rewriting the slot that owns the running conversion cancels that conversion. Writing any other slot leaves it alone.

The sample length, the converter clock divide ratio and the result resolution come from configuration inputs. These are captured at each start. Optional continuous mode restarts the same group after each completion. The overwrite enable decides whether an unread result may be replaced.

Top module: `adc_group_seq`

## Requirements
- R1: While reset is low and right after it: `done`, `conv_active`, `irq` and every result slot read 0.
- R2: In software mode (`hw_mode`=0), a write to slot 0 starts a conversion of group 0 at that edge. `conv_active` reads 1 from the next cycle until the completing edge. At completion, `done[0]` is set and result slot 0 is loaded.
- R3: In software mode, writes to slots 1 and above and any `hw_trig` request start nothing: `conv_active` stays 0 and no `done` bit is set.
- R4: In hardware mode, while idle, a `hw_trig` request starts the lowest-numbered requesting group. Requests that arrive while a conversion runs are ignored, and a write to slot 0 starts nothing.
- R5: Sample length in converter clocks: with `long_smp`=0 it is 2, 4, 6 or 8 for `smp_code` 0 to 3. With `long_smp`=1 it is 12, 16, 20 or 24. Sampling is followed by a fixed 4 converter clocks of conversion.
- R6: One converter clock lasts 1, 2, 4 or 8 clock cycles for `div_code` 0 to 3. A conversion therefore completes exactly (sample + 4) × ratio cycles after its start edge.
- R7: `res_code` 0 stores `ana_value` shifted right by 4 (8-bit), 1 shifts by 2 (10-bit), and 2 or 3 store all 12 bits, right-aligned.
- R8: A write to the slot of the group that is converting clears `conv_active` at that edge, and no result or `done` bit is produced.
- R9: A write to a slot other than the converting one does not change the running conversion's group, timing or result.
- R10: When `ovwr_en`=0 and `done[g]` is set, a new result for group g is discarded and the old value is kept. When `ovwr_en`=1, the new result replaces it.
- R11: A read strobe for group g clears `done[g]` at that edge. `irq` is 1 exactly when some group has both its `done` bit and its slot interrupt enable set.
- R12: With `cont_en`=1, a completing conversion restarts the same group at the same edge, so `conv_active` stays 1.
- R13: `conv_chan` shows the channel number held in the slot of the converting group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Slot write strobe |
| wr_grp | input | $clog2(NG) | Slot index for a write |
| wr_chan | input | 5 | Channel number to write |
| wr_ie | input | 1 | Completion interrupt enable to write |
| rd_en | input | 1 | Result acknowledge strobe |
| rd_grp | input | $clog2(NG) | Group being acknowledged |
| hw_mode | input | 1 | 1 = hardware trigger, 0 = software trigger |
| cont_en | input | 1 | Continuous conversion enable |
| ovwr_en | input | 1 | Allow replacing an unread result |
| long_smp | input | 1 | Long sample range select |
| smp_code | input | 2 | Sample length code |
| div_code | input | 2 | Converter clock divide code |
| res_code | input | 2 | Resolution code |
| hw_trig | input | NG | Per-group hardware start requests |
| ana_value | input | 12 | Stub sample value, taken at completion |
| conv_chan | output | 5 | Channel of the converting group |
| conv_active | output | 1 | Conversion in progress |
| act_grp | output | $clog2(NG) | Group owning the converter |
| done | output | NG | Per-group completion flags |
| result | output | NG*12 | Per-group results, group g at bits g*12 upward |
| irq | output | 1 | Completion interrupt |

## Verification
A start is taken at the edge that samples the write or trigger, so `conv_active`, `act_grp` and `conv_chan` are checked at the falling edge just after it. The result and the `done` flag are due exactly (sample + 4) × ratio edges after that start edge. The bench counts rising edges from the start edge to the falling edge where `conv_active` drops or `done` rises, and compares that count against the figure worked out from R5 and R6. An abort and a read acknowledge each take effect at their own sampling edge and are checked one half cycle later. The continuous-mode check expects a second completion at twice the single-conversion count, with no new write in between.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W       = 5;
  localparam int RES_W      = 12;
  localparam int CONV_TICKS = 4;
  localparam int CNT_W      = 6;
  localparam int DIV_W      = 4;

  // sample phase length in converter clocks
  function automatic logic [CNT_W-1:0] phase_ticks(input logic lng, input logic [1:0] code);
    logic [CNT_W-1:0] len;
    if (lng) len = CNT_W'(12) + CNT_W'({code, 2'b00});
    else     len = CNT_W'(2)  + CNT_W'({code, 1'b0});
    return len;
  endfunction

  function automatic logic [DIV_W-1:0] div_ratio(input logic [1:0] code);
    return DIV_W'(1) << code;
  endfunction

  function automatic logic [RES_W-1:0] scale_res(input logic [1:0] rc, input logic [RES_W-1:0] v);
    logic [RES_W-1:0] o;
    case (rc)
      2'd0:    o = v >> 4;
      2'd1:    o = v >> 2;
      default: o = v;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/adc_slot_bank.sv
module adc_slot_bank #(
  parameter int NG = 4,
  localparam int GW = $clog2(NG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [GW-1:0]                 wr_grp,
  input  logic [adc_seq_pkg::CH_W-1:0]  wr_chan,
  input  logic                          wr_ie,
  output logic [NG*adc_seq_pkg::CH_W-1:0] chan_flat,
  output logic [NG-1:0]                 ie
);
  import adc_seq_pkg::*;

  for (genvar g = 0; g < NG; g++) begin : g_slot
    logic            sel;
    logic [CH_W-1:0] chan_q, chan_d;
    logic            ie_q, ie_d;

    always_comb begin
      sel    = wr_en && (wr_grp == GW'(g));
      chan_d = chan_q;
      ie_d   = ie_q;
      if (sel) begin
        chan_d = wr_chan;
        ie_d   = wr_ie;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chan_q <= '0;
        ie_q   <= 1'b0;
      end else if (sel) begin
        chan_q <= chan_d;
        ie_q   <= ie_d;
      end
    end

    assign chan_flat[g*CH_W +: CH_W] = chan_q;
    assign ie[g]                     = ie_q;
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       busy,
  input  logic       long_smp,
  input  logic [1:0] smp_code,
  input  logic [1:0] div_code,
  input  logic [1:0] res_code,
  output logic       last_tick,
  output logic [1:0] res_l
);
  import adc_seq_pkg::*;

  logic [CNT_W-1:0] tot_m1_q, tot_m1_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] divm_q, divm_d;
  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic [1:0]       res_q, res_d;
  logic             tick, en;

  assign tick      = (dcnt_q == divm_q);
  assign last_tick = busy && tick && (cnt_q == tot_m1_q);
  assign res_l     = res_q;
  assign en        = start || busy;

  always_comb begin
    tot_m1_d = tot_m1_q;
    divm_d   = divm_q;
    res_d    = res_q;
    cnt_d    = cnt_q;
    dcnt_d   = dcnt_q;
    if (start) begin
      tot_m1_d = phase_ticks(long_smp, smp_code) + CNT_W'(CONV_TICKS) - CNT_W'(1);
      divm_d   = div_ratio(div_code) - DIV_W'(1);
      res_d    = res_code;
      cnt_d    = '0;
      dcnt_d   = '0;
    end else if (tick) begin
      dcnt_d = '0;
      cnt_d  = cnt_q + CNT_W'(1);
    end else begin
      dcnt_d = dcnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_m1_q <= '0;
      divm_q   <= '0;
      res_q    <= '0;
      cnt_q    <= '0;
      dcnt_q   <= '0;
    end else if (en) begin
      tot_m1_q <= tot_m1_d;
      divm_q   <= divm_d;
      res_q    <= res_d;
      cnt_q    <= cnt_d;
      dcnt_q   <= dcnt_d;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NG = 4,
  localparam int GW = $clog2(NG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [GW-1:0] wr_grp,
  input  logic          hw_mode,
  input  logic          cont_en,
  input  logic [NG-1:0] hw_trig,
  input  logic          last_tick,
  output logic          busy,
  output logic [GW-1:0] act_grp,
  output logic          start,
  output logic          complete
);
  logic          busy_q, busy_d;
  logic [GW-1:0] grp_q, grp_d;
  logic          same_hit, sw_go, hw_go, hw_any;
  logic [GW-1:0] hw_idx;

  // lowest-numbered requester wins
  always_comb begin
    hw_any = 1'b0;
    hw_idx = '0;
    for (int i = NG - 1; i >= 0; i--) begin
      if (hw_trig[i]) begin
        hw_any = 1'b1;
        hw_idx = GW'(i);
      end
    end
  end

  always_comb begin
    same_hit = wr_en && busy_q && (wr_grp == grp_q);
    sw_go    = !hw_mode && wr_en && (wr_grp == '0) && (!busy_q || grp_q == '0);
    hw_go    = hw_mode && !busy_q && hw_any;
    complete = last_tick && !same_hit;
    busy_d   = busy_q;
    grp_d    = grp_q;
    start    = 1'b0;
    if (sw_go) begin
      busy_d = 1'b1;
      grp_d  = '0;
      start  = 1'b1;
    end else if (same_hit) begin
      busy_d = 1'b0;
    end else if (last_tick) begin
      if (cont_en) start  = 1'b1;
      else         busy_d = 1'b0;
    end else if (hw_go) begin
      busy_d = 1'b1;
      grp_d  = hw_idx;
      start  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      grp_q  <= '0;
    end else begin
      busy_q <= busy_d;
      grp_q  <= grp_d;
    end
  end

  assign busy    = busy_q;
  assign act_grp = grp_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NG = 4,
  localparam int GW = $clog2(NG)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           complete,
  input  logic [GW-1:0]                  act_grp,
  input  logic [adc_seq_pkg::RES_W-1:0]  ana_value,
  input  logic [1:0]                     res_l,
  input  logic                           ovwr_en,
  input  logic                           rd_en,
  input  logic [GW-1:0]                  rd_grp,
  output logic [NG-1:0]                  done,
  output logic [NG*adc_seq_pkg::RES_W-1:0] result
);
  import adc_seq_pkg::*;

  logic [RES_W-1:0] scaled;
  assign scaled = scale_res(res_l, ana_value);

  for (genvar g = 0; g < NG; g++) begin : g_res
    logic             hit, accept, rd_clr;
    logic             done_q, done_d;
    logic [RES_W-1:0] res_q, res_d;

    always_comb begin
      hit    = complete && (act_grp == GW'(g));
      accept = hit && (!done_q || ovwr_en);
      rd_clr = rd_en && (rd_grp == GW'(g));
      done_d = accept || (done_q && !rd_clr);
      res_d  = accept ? scaled : res_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q <= 1'b0;
        res_q  <= '0;
      end else begin
        done_q <= done_d;
        if (accept) res_q <= res_d;
      end
    end

    assign done[g]                    = done_q;
    assign result[g*RES_W +: RES_W]   = res_q;
  end
endmodule

// File: rtl/adc_group_seq.sv
module adc_group_seq #(
  parameter int NG = 4,
  localparam int GW = $clog2(NG)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [GW-1:0]                    wr_grp,
  input  logic [adc_seq_pkg::CH_W-1:0]     wr_chan,
  input  logic                             wr_ie,
  input  logic                             rd_en,
  input  logic [GW-1:0]                    rd_grp,
  input  logic                             hw_mode,
  input  logic                             cont_en,
  input  logic                             ovwr_en,
  input  logic                             long_smp,
  input  logic [1:0]                       smp_code,
  input  logic [1:0]                       div_code,
  input  logic [1:0]                       res_code,
  input  logic [NG-1:0]                    hw_trig,
  input  logic [adc_seq_pkg::RES_W-1:0]    ana_value,
  output logic [adc_seq_pkg::CH_W-1:0]     conv_chan,
  output logic                             conv_active,
  output logic [GW-1:0]                    act_grp,
  output logic [NG-1:0]                    done,
  output logic [NG*adc_seq_pkg::RES_W-1:0] result,
  output logic                             irq
);
  import adc_seq_pkg::*;

  logic [NG*CH_W-1:0] chan_flat;
  logic [NG-1:0]      ie;
  logic               start, complete, last_tick, busy;
  logic [1:0]         res_l;

  adc_slot_bank #(.NG(NG)) u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
    .wr_chan(wr_chan), .wr_ie(wr_ie), .chan_flat(chan_flat), .ie(ie)
  );

  adc_seq_ctrl #(.NG(NG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
    .hw_mode(hw_mode), .cont_en(cont_en), .hw_trig(hw_trig),
    .last_tick(last_tick), .busy(busy), .act_grp(act_grp),
    .start(start), .complete(complete)
  );

  adc_conv_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .long_smp(long_smp), .smp_code(smp_code), .div_code(div_code),
    .res_code(res_code), .last_tick(last_tick), .res_l(res_l)
  );

  adc_result_bank #(.NG(NG)) u_res (
    .clk(clk), .rst_n(rst_n), .complete(complete), .act_grp(act_grp),
    .ana_value(ana_value), .res_l(res_l), .ovwr_en(ovwr_en),
    .rd_en(rd_en), .rd_grp(rd_grp), .done(done), .result(result)
  );

  always_comb begin
    conv_chan = '0;
    for (int i = 0; i < NG; i++) begin
      if (act_grp == GW'(i)) conv_chan = chan_flat[i*CH_W +: CH_W];
    end
  end

  assign conv_active = busy;
  assign irq         = |(done & ie);
endmodule

// File: rtl/adc_group_seq_chk.sv
module adc_group_seq_chk #(
  parameter int NG = 4,
  localparam int GW = $clog2(NG)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic [GW-1:0]                    wr_grp,
  input logic                             rd_en,
  input logic [GW-1:0]                    rd_grp,
  input logic                             hw_mode,
  input logic                             ovwr_en,
  input logic                             conv_active,
  input logic [GW-1:0]                    act_grp,
  input logic [NG-1:0]                    done,
  input logic [NG*adc_seq_pkg::RES_W-1:0] result,
  input logic                             irq
);
  import adc_seq_pkg::*;

  logic [GW-1:0] rd_grp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_grp_q <= '0;
    else        rd_grp_q <= rd_grp;
  end

  // R3: software mode, nothing but a slot-0 write may start
  a_r3_sw_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_mode && !conv_active && !(wr_en && wr_grp == '0)) |=> !conv_active);

  // R8: rewriting the converting slot aborts
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && wr_en && wr_grp == act_grp && (hw_mode || wr_grp != '0)) |=> !conv_active);

  // R4 / R9: owning group does not change mid-conversion without a write
  a_r4_grp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && !wr_en) |=> (!conv_active || $stable(act_grp)));

  // R11: no done flag, no interrupt
  a_r11_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (done == '0) |-> !irq);

  // R11: acknowledge clears the flag when no completion can collide
  a_r11_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !conv_active) |=> !done[rd_grp_q]);

  for (genvar g = 0; g < NG; g++) begin : g_keep
    // R10: unread result kept when overwrite is off
    a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovwr_en && done[g] && !(rd_en && rd_grp == GW'(g)))
        |=> $stable(result[g*RES_W +: RES_W]));
  end
endmodule

bind adc_group_seq adc_group_seq_chk #(.NG(NG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
  .rd_en(rd_en), .rd_grp(rd_grp), .hw_mode(hw_mode), .ovwr_en(ovwr_en),
  .conv_active(conv_active), .act_grp(act_grp), .done(done),
  .result(result), .irq(irq)
);

// File: tb/tb_adc_group_seq.sv
`timescale 1ns/1ps
module tb_adc_group_seq;
  localparam int NG = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_ie, rd_en, hw_mode, cont_en, ovwr_en, long_smp;
  logic [1:0]  wr_grp, rd_grp, smp_code, div_code, res_code;
  logic [4:0]  wr_chan;
  logic [NG-1:0] hw_trig;
  logic [11:0] ana_value;
  logic [4:0]  conv_chan;
  logic        conv_active, irq;
  logic [1:0]  act_grp;
  logic [NG-1:0] done;
  logic [NG*12-1:0] result;

  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_group_seq #(.NG(NG)) dut (.*);

  typedef struct packed {
    logic        lng;
    logic [1:0]  smp;
    logic [1:0]  dv;
    logic [1:0]  rs;
    logic [11:0] ana;
    logic [4:0]  ch;
    logic [11:0] exp_res;
    logic [15:0] exp_cyc;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 2'd0, 2'd0, 2'd2, 12'hABC, 5'd3,  12'hABC, 16'd6},
    '{1'b0, 2'd3, 2'd1, 2'd0, 12'hABC, 5'd7,  12'h0AB, 16'd24},
    '{1'b1, 2'd0, 2'd0, 2'd1, 12'h5A5, 5'd31, 12'h169, 16'd16},
    '{1'b1, 2'd3, 2'd2, 2'd2, 12'h123, 5'd0,  12'h123, 16'd112},
    '{1'b0, 2'd1, 2'd3, 2'd3, 12'hFFF, 5'd9,  12'hFFF, 16'd64},
    '{1'b1, 2'd2, 2'd0, 2'd0, 12'h0F0, 5'd15, 12'h00F, 16'd24}
  };

  function automatic logic [11:0] res_of(int g);
    return result[g*12 +: 12];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int g, input int ch, input bit ie);
    @(negedge clk);
    wr_en = 1'b1; wr_grp = 2'(g); wr_chan = 5'(ch); wr_ie = ie;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int g);
    @(negedge clk);
    rd_en = 1'b1; rd_grp = 2'(g);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // software conversion on group 0; returns cycles from start edge to idle
  task automatic sw_conv(input int ch, input bit ie, input logic [11:0] ana,
                         output int n, output int chan_seen, output bit act_seen);
    int c0;
    ana_value = ana;
    wr(0, ch, ie);
    c0 = cyc;
    act_seen  = conv_active;
    chan_seen = conv_chan;
    while (conv_active && (cyc - c0) < 400) @(negedge clk);
    n = cyc - c0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, cs, c0;
    bit as;
    rst_n = 1'b0; wr_en = 0; wr_ie = 0; rd_en = 0; hw_mode = 0; cont_en = 0;
    ovwr_en = 0; long_smp = 0; wr_grp = 0; rd_grp = 0; smp_code = 0;
    div_code = 0; res_code = 2; wr_chan = 0; hw_trig = 0; ana_value = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 0 && !conv_active && !irq && result == 0, "R1 reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!conv_active && done == 0, "R1 after release", conv_active, 0);

    // table of software conversions: R2 R5 R6 R7 R13
    foreach (VEC[i]) begin
      long_smp = VEC[i].lng; smp_code = VEC[i].smp;
      div_code = VEC[i].dv;  res_code = VEC[i].rs;
      sw_conv(VEC[i].ch, 1'b0, VEC[i].ana, n, cs, as);
      chk(as, "R2 active after start", as, 1);
      chk(cs == VEC[i].ch, "R13 conv_chan", cs, VEC[i].ch);
      chk(n == VEC[i].exp_cyc, "R5/R6 latency", n, VEC[i].exp_cyc);
      chk(done[0] && res_of(0) == VEC[i].exp_res, "R7 result", res_of(0), VEC[i].exp_res);
      rd(0);
      chk(!done[0], "R11 read clears", done[0], 0);
    end
    long_smp = 0; smp_code = 0; div_code = 0; res_code = 2;

    // R3: software mode, other slots and triggers start nothing
    wr(2, 6, 1'b0);
    chk(!conv_active, "R3 slot2 write", conv_active, 0);
    @(negedge clk); hw_trig = 4'b1111;
    @(negedge clk); hw_trig = 4'b0000;
    chk(!conv_active, "R3 trigger in sw mode", conv_active, 0);
    repeat (10) @(negedge clk);
    chk(done == 0, "R3 no done", done, 0);

    // R4 / R9: hardware mode ping-pong
    hw_mode = 1'b1;
    wr(1, 9, 1'b0);
    chk(!conv_active, "R4 write no start", conv_active, 0);
    ana_value = 12'h456;
    @(negedge clk); hw_trig = 4'b0110;
    @(negedge clk); hw_trig = 4'b1000;
    c0 = cyc;
    chk(conv_active && act_grp == 2'd1, "R4 lowest group wins", act_grp, 1);
    chk(conv_chan == 5'd9, "R13 hw channel", conv_chan, 9);
    wr_en = 1'b1; wr_grp = 2'd0; wr_chan = 5'd4;
    @(negedge clk); hw_trig = 0; wr_en = 1'b0;
    chk(act_grp == 2'd1 && conv_active, "R9 other write keeps", act_grp, 1);
    while (!done[1] && (cyc - c0) < 100) @(negedge clk);
    chk(cyc - c0 == 6, "R9 timing undisturbed", cyc - c0, 6);
    chk(done == 4'b0010 && res_of(1) == 12'h456, "R4 only group1 done", done, 2);
    rd(1);

    // R8: rewrite the converting slot aborts
    wr(2, 5, 1'b0);
    @(negedge clk); hw_trig = 4'b0100;
    @(negedge clk); hw_trig = 4'b0000;
    chk(conv_active && act_grp == 2'd2, "R8 started", act_grp, 2);
    @(negedge clk);
    wr_en = 1'b1; wr_grp = 2'd2; wr_chan = 5'd5;
    @(negedge clk); wr_en = 1'b0;
    chk(!conv_active, "R8 abort", conv_active, 0);
    repeat (10) @(negedge clk);
    chk(!done[2], "R8 no result", done[2], 0);
    hw_mode = 1'b0;

    // R10: overwrite control
    sw_conv(1, 1'b0, 12'h111, n, cs, as);
    chk(res_of(0) == 12'h111, "R10 first", res_of(0), 12'h111);
    sw_conv(1, 1'b0, 12'h222, n, cs, as);
    chk(done[0] && res_of(0) == 12'h111, "R10 discard", res_of(0), 12'h111);
    ovwr_en = 1'b1;
    sw_conv(1, 1'b0, 12'h333, n, cs, as);
    chk(res_of(0) == 12'h333, "R10 replace", res_of(0), 12'h333);
    chk(!irq, "R11 no irq without enable", irq, 0);
    rd(0);
    ovwr_en = 1'b0;

    // R11: interrupt follows done and enable
    sw_conv(2, 1'b1, 12'h044, n, cs, as);
    chk(irq, "R11 irq set", irq, 1);
    rd(0);
    chk(!irq && !done[0], "R11 irq cleared", irq, 0);

    // R12: continuous conversion
    cont_en = 1'b1;
    ana_value = 12'h0AA;
    wr(0, 3, 1'b0);
    c0 = cyc;
    while (!done[0] && (cyc - c0) < 100) @(negedge clk);
    chk(cyc - c0 == 6 && conv_active, "R12 first pass", cyc - c0, 6);
    ana_value = 12'h0BB;
    rd_en = 1'b1; rd_grp = 2'd0;
    @(negedge clk); rd_en = 1'b0;
    chk(!done[0] && conv_active, "R12 restarted", conv_active, 1);
    while (!done[0] && (cyc - c0) < 100) @(negedge clk);
    chk(cyc - c0 == 12 && res_of(0) == 12'h0BB, "R12 second pass", cyc - c0, 12);
    cont_en = 1'b0;
    while (conv_active && (cyc - c0) < 100) @(negedge clk);
    chk(cyc - c0 == 18, "R12 stops", cyc - c0, 18);
    rd(0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule